// File: doc/BRIEF.md
# Parallel Quarter-Rate Duobinary Precoder

This block precodes data for duobinary signalling. It works on parallel words rather than on the serial line rate. On every cycle of a clock running at one quarter of the bit rate it can accept a word of `LANES` bits (four by default). It returns the same number of precoded bits. Each precoded bit is the XOR of its data bit and the precoded bit sent just before it. The chain runs through the word and then on into the next word. A serializer placed after the block sends the precoded word out bit by bit.

The serial recurrence is unrolled across the word. In the first stage the block computes two candidate words from the prefix XOR of the incoming bits. One candidate assumes that the previous precoded bit was 0 and the other assumes it was 1. Both candidates go into registers. In the second stage, the last bit of the most recent precoded word selects one candidate. That bit is the only state carried from word to word, so the slow loop holds just a register and a multiplexer. Idle cycles do not break the chain, because the carried bit keeps its value until the next valid word arrives.

Top module: `duo_precoder_q`

## Requirements
- R1: Bit 0 of `din` is the earliest bit in time and the highest bit is the latest, and `dout` uses the same order. For a valid output word, `dout[k]` equals `din[0] ^ ... ^ din[k] ^ p`, where `din` is the input word that produced it.
- R2: `p` is the highest bit of the most recent earlier valid output word, or 0 if there has been no valid word since reset.
- R3: `out_valid` rises after exactly two rising clock edges once a word is presented with `in_valid` high, and it stays low for words presented with `in_valid` low.
- R4: While `rst_n` is low, `out_valid` and `dout` are 0, and `in_valid` has no effect.
- R5: Idle cycles (`in_valid` low) of any length between valid words leave the carried bit unchanged, so the recurrence continues across the gap.
- R6: While `out_valid` is low, `dout` holds the value of the most recent valid word, or 0 after reset.
- R7: A valid word may be presented on every cycle. Back-to-back words each get the correct carried bit from the word just before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `din` carries a word this cycle |
| din | input | LANES | Data word, bit 0 earliest |
| out_valid | output | 1 | `dout` carries a precoded word this cycle |
| dout | output | LANES | Precoded word, bit 0 earliest |

## Verification
In the same cycle, the block selects the output for one word using the carried bit and latches the candidates of the next word. The carried bit is therefore updated in the cycle in which it is also needed. The bench provokes this with long runs of back-to-back words and with gaps of one cycle and of several cycles. These are mixed with directed all-zeros and all-ones words, and with a reset applied in the middle of a stream while `in_valid` is high. Every output is judged against a bit-serial model of the recurrence that carries its own previous bit.

// File: rtl/duo_precoder_q.sv
module duo_precoder_q #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LANES-1:0] din,
  output logic             out_valid,
  output logic [LANES-1:0] dout
);
  localparam int TOP = LANES - 1;

  logic [LANES-1:0] run_par;
  logic [LANES-1:0] cand_lo, cand_hi, pick;
  logic             cand_vld;

  // prefix parity of the word, i.e. the result when the carried bit is 0
  assign run_par[0] = din[0];
  generate
    for (genvar k = 1; k < LANES; k++) begin : g_pfx
      assign run_par[k] = run_par[k-1] ^ din[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_vld <= 1'b0;
      cand_lo  <= '0;
      cand_hi  <= '0;
    end else begin
      cand_vld <= in_valid;
      if (in_valid) begin
        cand_lo <= run_par;
        cand_hi <= ~run_par;
      end
    end
  end

  // dout[TOP] only changes on valid words, so it is the carried bit
  assign pick = dout[TOP] ? cand_hi : cand_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else begin
      out_valid <= cand_vld;
      if (cand_vld) dout <= pick;
    end
  end
endmodule

module duo_precoder_q_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [LANES-1:0] din,
  input logic             out_valid,
  input logic [LANES-1:0] dout
);
  localparam int TOP = LANES - 1;

  logic             v1, v2, prev_q;
  logic [LANES-1:0] d1, d2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; d1 <= '0; d2 <= '0; prev_q <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      d1 <= din;
      d2 <= d1;
      if (out_valid) prev_q <= dout[TOP];
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v2); // R3
  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((dout ^ {dout[LANES-2:0], prev_q}) == d2)); // R1
  AST_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dout[0] == (d2[0] ^ prev_q))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(dout)); // R6
endmodule

bind duo_precoder_q duo_precoder_q_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/duo_precoder_q_test.sv
module duo_precoder_q_test;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [LANES-1:0] din = '0;
  logic             out_valid;
  logic [LANES-1:0] dout;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  logic             ref_prev = 1'b0;
  logic [LANES-1:0] ref_last = '0;
  logic             e1_v = 1'b0, e2_v = 1'b0;
  logic [LANES-1:0] e1_d = '0, e2_d = '0;

  always #2.5 clk = ~clk;

  duo_precoder_q #(.LANES(LANES)) uut (.*);

  function automatic logic [LANES-1:0] serial_model(input logic p, input logic [LANES-1:0] d);
    logic [LANES-1:0] r;
    logic b = p;
    for (int k = 0; k < LANES; k++) begin
      b = b ^ d[k];
      r[k] = b;
    end
    return r;
  endfunction

  task automatic chk(input string t, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b at cycle %0d", t, got, exp, cycles);
    end
  endtask

  // runs at a falling edge: judge the outputs, then present the next input
  task automatic step(input logic v, input logic [LANES-1:0] d);
    logic [LANES-1:0] w;
    chk("R3", {{(LANES-1){1'b0}}, out_valid}, {{(LANES-1){1'b0}}, e2_v});
    chk(e2_v ? tag : "R6", dout, e2_d);
    e2_v = e1_v; e2_d = e1_d;
    if (v) begin
      w = serial_model(ref_prev, d);
      ref_prev = w[LANES-1];
      ref_last = w;
    end
    e1_v = v; e1_d = ref_last;
    in_valid = v; din = d;
    @(negedge clk);
  endtask

  task automatic do_reset(input int n);
    rst_n = 1'b0;
    in_valid = 1'b1; din = '1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R4", {{(LANES-1){1'b0}}, out_valid}, '0);
      chk("R4", dout, '0);
    end
    rst_n = 1'b1; in_valid = 1'b0; din = '0;
    ref_prev = 1'b0; ref_last = '0;
    e1_v = 1'b0; e2_v = 1'b0; e1_d = '0; e2_d = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got hang expected finish");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    logic v;
    seed = $urandom(32'h5eed_0d0b);
    @(negedge clk);
    do_reset(3);
    // R2: first word after reset uses carried bit 0
    tag = "R2";
    step(1'b1, 4'b0001);
    // R5: idle gap of several cycles, then all-zeros must keep carried 1
    tag = "R5";
    for (int i = 0; i < 5; i++) step(1'b0, 4'b1010);
    step(1'b1, 4'b0000);
    step(1'b0, 4'b0000);
    step(1'b1, 4'b1111);
    // R7: back-to-back bursts
    tag = "R7";
    for (int i = 0; i < 40; i++) step(1'b1, LANES'($urandom));
    // R1: random stream with gaps
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      v = ($urandom % 4) != 0;
      step(v, LANES'($urandom));
    end
    for (int i = 0; i < 2; i++) step(1'b0, '0);
    // R4: reset mid-stream while words arrive
    tag = "R4";
    step(1'b1, 4'b0111);
    do_reset(2);
    tag = "R2";
    step(1'b1, 4'b1000);
    step(1'b1, 4'b1000);
    tag = "R1";
    for (int i = 0; i < 500; i++) step(($urandom % 2) == 0, LANES'($urandom));
    for (int i = 0; i < 3; i++) step(1'b0, '0);
    finish_run();
  end
endmodule